// File: doc/BRIEF.md
# Dynamic-Mode Transmit Command Decoder

This block is the command front end of a two-wire bus master that runs in a dynamic mode. Software writes 10-bit command words into a 16-entry transmit queue. In each word, bits 7:0 carry a byte, bit 8 asks for a start condition in front of that byte, and bit 9 asks for a stop condition after it. The decoder takes the words one at a time. It turns each into a series of actions for a byte-level engine: start, repeated start, send byte, receive byte (with or without acknowledge) and stop. It hands these actions over one at a time through a request/done handshake.

A word that carries the start flag is an address word. Its byte is the 7-bit target address shifted left by one. Bit 0 of that byte gives the direction: 1 for a read, 0 for a write. In a read transfer the next word carries the stop flag, and its low byte is the number of bytes to receive. The decoder counts those bytes down. It withholds acknowledge on the last one and then closes with a stop. Received bytes go into a 16-entry receive queue. While that queue is full, the engine is held off, so no data is lost. Bit-level line timing belongs to the byte engine and is not part of this block.

Top module: `dyn_cmd_decoder`

## Requirements
- R1: A word with bit 8 set, while the bus is not owned, produces a start action (op code 1) and then a send action (op code 3) whose byte is bits 7:0 of the word. Bit 0 of that byte selects read (1) or write (0) for the transfer.
- R2: A word with bit 8 set, while the bus is still owned, produces a repeated-start action (op code 2) in place of a start, followed by the send of its address byte.
- R3: A word with both bit 8 and bit 9 set performs a complete address-only transfer: start, send of the address byte, then a stop action (op code 5). Afterwards the bus is released.
- R4: In a read transfer, a word with bit 9 set and low byte N produces N receive actions (op code 4), then a stop. The nack output is high on the final receive only. When N is 0, only the stop is issued.
- R5: In an open write transfer, a word without bit 8 produces a send of its byte. When bit 9 is set, a stop follows.
- R6: Only one action is requested at a time. While the request is waiting for done, the op code and byte hold steady. Each action is issued once.
- R7: The transmit queue holds 16 words and reports full, empty and an occupancy count. A write into a full queue is dropped and sets a sticky overflow flag.
- R8: A word without bit 8 is discarded with no action issued, and a sticky protocol-error flag is set, in two cases: when no transfer is open, or when it arrives in an open read transfer without bit 9.
- R9: Received bytes enter a 16-entry receive queue in arrival order. While that queue is full, no receive request is raised. The queue reports full and empty.
- R10: bus_busy rises when a start action completes and falls when a stop action completes.
- R11: After reset, both queues are empty with occupancy 0, and no request, busy, overflow or error flag is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_wr | input | 1 | Write strobe for the transmit queue |
| cmd_word | input | 10 | Command word: byte in 7:0, start in 8, stop in 9 |
| eng_req | output | 1 | Action request to the byte engine |
| eng_op | output | 3 | Action code: 1 start, 2 repeated start, 3 send, 4 receive, 5 stop |
| eng_byte | output | 8 | Byte to send |
| eng_nack | output | 1 | Withhold acknowledge on this receive |
| eng_done | input | 1 | Engine finished the requested action |
| eng_rx_byte | input | 8 | Byte received, valid with done on a receive |
| rx_pop | input | 1 | Pop strobe for the receive queue |
| rx_byte | output | 8 | Head of the receive queue |
| tx_full | output | 1 | Transmit queue full |
| tx_empty | output | 1 | Transmit queue empty |
| tx_level | output | 5 | Transmit queue occupancy |
| rx_full | output | 1 | Receive queue full |
| rx_empty | output | 1 | Receive queue empty |
| bus_busy | output | 1 | The master owns the bus |
| tx_overflow | output | 1 | Sticky: a write was dropped |
| proto_err | output | 1 | Sticky: a word was discarded |

## Verification
A queue write shows up in the occupancy count and flags one clock after its strobe edge. The decoder raises its request one clock later than that. The modelled engine answers with done a fixed number of clocks after it sees the request, and the next action appears in the clock after done. The bench does not try to predict each of these edges. For action sequences it logs every done handshake and compares the whole log once the queue has stayed empty with no request for several clocks. Flags, levels and queue heads are sampled on falling edges, at least one full clock after the stimulus that changed them.

// File: rtl/dyn_cmd_pkg.sv
// Shared types for the dynamic-mode command decoder.
// Assumes: engine action codes are fixed by the engine interface.
package dyn_cmd_pkg;
    typedef enum logic [2:0] {
        OP_NONE   = 3'd0,
        OP_START  = 3'd1,
        OP_RSTART = 3'd2,
        OP_SEND   = 3'd3,
        OP_RECV   = 3'd4,
        OP_STOP   = 3'd5
    } eng_op_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START,
        ST_ADDR,
        ST_DATA,
        ST_RECV,
        ST_STOP
    } seq_state_e;

    localparam int BYTE_W  = 8;
    localparam int WORD_W  = 10;
    localparam int BIT_STA = 8;
    localparam int BIT_STO = 9;
endpackage

// File: rtl/dyn_fifo.sv
// Synchronous first-in first-out queue with a head-of-queue view.
// Assumes: DEPTH is a power of two; a push when full and a pop when empty
// are both ignored; the head is valid whenever empty is low.
module dyn_fifo #(
    parameter int W     = 10,
    parameter int DEPTH = 16,
    localparam int AW   = $clog2(DEPTH),
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic [W-1:0]  push_data,
    input  logic          pop,
    output logic [W-1:0]  head,
    output logic          full,
    output logic          empty,
    output logic [CW-1:0] level
);
    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wptr, rptr;
    logic          do_push, do_pop;

    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign full    = (level == CW'(DEPTH));
    assign empty   = (level == '0);
    assign head    = mem[rptr];

    // Storage write: only accepted pushes touch the array.
    always_ff @(posedge clk) begin
        if (do_push) mem[wptr] <= push_data;
    end

    // Pointer and occupancy upkeep.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wptr  <= '0;
            rptr  <= '0;
            level <= '0;
        end else begin
            if (do_push) wptr <= wptr + 1'b1;
            if (do_pop)  rptr <= rptr + 1'b1;
            case ({do_push, do_pop})
                2'b10:   level <= level + 1'b1;
                2'b01:   level <= level - 1'b1;
                default: level <= level;
            endcase
        end
    end

    assert_level_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
        level <= CW'(DEPTH));
    assert_no_overflow_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (full && push && !pop) |=> (full && level == $past(level)));
endmodule

// File: rtl/dyn_cmd_seq.sv
// Command sequencer: decodes the word at the head of the transmit queue
// into engine actions and pops it once its last action is done.
// Assumes: the head stays stable until popped; eng_done is honoured only
// while eng_req is high.
module dyn_cmd_seq
    import dyn_cmd_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [WORD_W-1:0] head,
    input  logic              tx_empty,
    output logic              tx_pop,
    input  logic              rx_full,
    output logic              rx_push,
    output logic [BYTE_W-1:0] rx_push_data,
    output logic              eng_req,
    output logic [2:0]        eng_op,
    output logic [BYTE_W-1:0] eng_byte,
    output logic              eng_nack,
    input  logic              eng_done,
    input  logic [BYTE_W-1:0] eng_rx_byte,
    output logic              bus_busy,
    output logic              proto_err
);
    seq_state_e       state;
    logic             rd_mode;
    logic [CNT_W-1:0] rcnt;
    logic             go, h_sta, h_sto, discard;

    assign h_sta   = head[BIT_STA];
    assign h_sto   = head[BIT_STO];
    assign go      = eng_req && eng_done;
    assign discard = !tx_empty && !h_sta && (!bus_busy || (rd_mode && !h_sto));
    assign rx_push = (state == ST_RECV) && go;
    assign rx_push_data = eng_rx_byte;

    // Request, action code and byte presented to the engine per state.
    always_comb begin
        eng_req  = 1'b0;
        eng_op   = OP_NONE;
        eng_byte = '0;
        eng_nack = 1'b0;
        case (state)
            ST_START: begin
                eng_req = 1'b1;
                eng_op  = bus_busy ? OP_RSTART : OP_START;
            end
            ST_ADDR, ST_DATA: begin
                eng_req  = 1'b1;
                eng_op   = OP_SEND;
                eng_byte = head[BYTE_W-1:0];
            end
            ST_RECV: begin
                eng_req  = !rx_full;
                eng_op   = OP_RECV;
                eng_nack = (rcnt == CNT_W'(1));
            end
            ST_STOP: begin
                eng_req = 1'b1;
                eng_op  = OP_STOP;
            end
            default: ;
        endcase
    end

    // Pop the head once it is discarded or its final action is done.
    always_comb begin
        tx_pop = 1'b0;
        case (state)
            ST_IDLE:          tx_pop = discard;
            ST_ADDR, ST_DATA: tx_pop = go && !h_sto;
            ST_STOP:          tx_pop = go;
            default:          tx_pop = 1'b0;
        endcase
    end

    // State walk, bus ownership, direction, receive count and error flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ST_IDLE;
            rd_mode   <= 1'b0;
            rcnt      <= '0;
            bus_busy  <= 1'b0;
            proto_err <= 1'b0;
        end else begin
            case (state)
                ST_IDLE: if (!tx_empty) begin
                    if (h_sta)          state <= ST_START;
                    else if (discard)   proto_err <= 1'b1;
                    else if (rd_mode) begin
                        rcnt  <= head[CNT_W-1:0];
                        state <= (head[CNT_W-1:0] == '0) ? ST_STOP : ST_RECV;
                    end else            state <= ST_DATA;
                end
                ST_START: if (go) begin
                    bus_busy <= 1'b1;
                    state    <= ST_ADDR;
                end
                ST_ADDR: if (go) begin
                    rd_mode <= head[0];
                    state   <= h_sto ? ST_STOP : ST_IDLE;
                end
                ST_DATA: if (go) state <= h_sto ? ST_STOP : ST_IDLE;
                ST_RECV: if (go) begin
                    rcnt <= rcnt - 1'b1;
                    if (rcnt == CNT_W'(1)) state <= ST_STOP;
                end
                ST_STOP: if (go) begin
                    bus_busy <= 1'b0;
                    rd_mode  <= 1'b0;
                    state    <= ST_IDLE;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    assert_req_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (eng_req && !eng_done) |=> (eng_req && $stable(eng_op) && $stable(eng_byte)));
    assert_last_nack_stop_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (eng_req && eng_done && eng_op == OP_RECV && eng_nack) |=> (eng_op == OP_STOP));
    assert_rx_stall_R9: assert property (@(posedge clk) disable iff (!rst_n)
        rx_full |-> !(eng_req && eng_op == OP_RECV));
    assert_busy_rise_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bus_busy) |-> $past(eng_done && eng_op == OP_START));
    assert_err_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
        proto_err |=> proto_err);
endmodule

// File: rtl/dyn_cmd_decoder.sv
// Top of the dynamic-mode command decoder: transmit queue, sequencer and
// receive queue, plus the sticky overflow flag for dropped writes.
// Assumes: the byte engine holds done for one clock per action.
module dyn_cmd_decoder
    import dyn_cmd_pkg::*;
#(
    parameter int TX_DEPTH = 16,
    parameter int RX_DEPTH = 16,
    localparam int TLW     = $clog2(TX_DEPTH + 1),
    localparam int RLW     = $clog2(RX_DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_wr,
    input  logic [WORD_W-1:0] cmd_word,
    output logic              eng_req,
    output logic [2:0]        eng_op,
    output logic [BYTE_W-1:0] eng_byte,
    output logic              eng_nack,
    input  logic              eng_done,
    input  logic [BYTE_W-1:0] eng_rx_byte,
    input  logic              rx_pop,
    output logic [BYTE_W-1:0] rx_byte,
    output logic              tx_full,
    output logic              tx_empty,
    output logic [TLW-1:0]    tx_level,
    output logic              rx_full,
    output logic              rx_empty,
    output logic              bus_busy,
    output logic              tx_overflow,
    output logic              proto_err
);
    logic [WORD_W-1:0] tx_head;
    logic              tx_pop, rx_push;
    logic [BYTE_W-1:0] rx_push_data;
    logic [RLW-1:0]    rx_level;

    dyn_fifo #(.W(WORD_W), .DEPTH(TX_DEPTH)) u_txq (
        .clk(clk), .rst_n(rst_n),
        .push(cmd_wr), .push_data(cmd_word), .pop(tx_pop),
        .head(tx_head), .full(tx_full), .empty(tx_empty), .level(tx_level)
    );

    dyn_cmd_seq #(.CNT_W(BYTE_W)) u_seq (
        .clk(clk), .rst_n(rst_n),
        .head(tx_head), .tx_empty(tx_empty), .tx_pop(tx_pop),
        .rx_full(rx_full), .rx_push(rx_push), .rx_push_data(rx_push_data),
        .eng_req(eng_req), .eng_op(eng_op), .eng_byte(eng_byte),
        .eng_nack(eng_nack), .eng_done(eng_done), .eng_rx_byte(eng_rx_byte),
        .bus_busy(bus_busy), .proto_err(proto_err)
    );

    dyn_fifo #(.W(BYTE_W), .DEPTH(RX_DEPTH)) u_rxq (
        .clk(clk), .rst_n(rst_n),
        .push(rx_push), .push_data(rx_push_data), .pop(rx_pop),
        .head(rx_byte), .full(rx_full), .empty(rx_empty), .level(rx_level)
    );

    // Sticky record of any write attempted while the transmit queue is full.
    always_ff @(posedge clk) begin
        if (!rst_n)                 tx_overflow <= 1'b0;
        else if (cmd_wr && tx_full) tx_overflow <= 1'b1;
    end

    assert_overflow_cause_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tx_overflow) |-> $past(cmd_wr && tx_full));
    assert_rx_level_R9: assert property (@(posedge clk) disable iff (!rst_n)
        rx_push |-> !rx_full);
endmodule

// File: tb/tb_dyn_cmd_decoder.sv
module tb_dyn_cmd_decoder;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0, rst_n = 1'b0;
    logic       cmd_wr = 1'b0;
    logic [9:0] cmd_word = '0;
    logic       eng_req, eng_nack, eng_done = 1'b0;
    logic [2:0] eng_op;
    logic [7:0] eng_byte, eng_rx_byte = '0, rx_byte;
    logic       rx_pop = 1'b0;
    logic       tx_full, tx_empty, rx_full, rx_empty, bus_busy, tx_overflow, proto_err;
    logic [4:0] tx_level;

    dyn_cmd_decoder dut (.*);

    always #(CLK_PERIOD/2) clk = ~clk;

    int n_chk = 0, n_bad = 0;
    int log_op [0:1023]; int log_byte [0:1023]; int log_nack [0:1023];
    int log_n = 0;
    int e_op [0:255]; int e_byte [0:255]; int e_nack [0:255];
    int e_n = 0, base = 0;
    int rx_seq = 0, pop_seq = 0;
    int lat = 2, cnt = 0;
    bit hold = 1'b0, fin = 1'b0;

    // Byte engine model: answers each request after lat clocks, logs it.
    always @(negedge clk) begin
        if (!rst_n) begin
            eng_done = 1'b0; cnt = 0;
        end else if (eng_done) begin
            eng_done = 1'b0;
        end else if (eng_req && !hold) begin
            if (cnt == lat) begin
                log_op[log_n] = int'(eng_op); log_byte[log_n] = int'(eng_byte);
                log_nack[log_n] = int'(eng_nack); log_n++;
                if (eng_op == 3'd4) begin
                    eng_rx_byte = 8'(rx_seq); rx_seq++;
                end
                eng_done = 1'b1; cnt = 0;
            end else cnt++;
        end
    end

    task automatic chk(bit ok, string req, int act, int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic ex(int op, int b, int nk);
        e_op[e_n] = op; e_byte[e_n] = b; e_nack[e_n] = nk; e_n++;
    endtask

    // Compare logged actions with the expected list (R6: each issued once).
    task automatic check_log(string req);
        chk((log_n - base) == e_n, {req, " R6 action count"}, log_n - base, e_n);
        for (int i = 0; i < e_n && i < log_n - base; i++) begin
            chk(log_op[base+i] == e_op[i], {req, " op"}, log_op[base+i], e_op[i]);
            if (e_op[i] == 3)
                chk(log_byte[base+i] == e_byte[i], {req, " byte"}, log_byte[base+i], e_byte[i]);
            if (e_op[i] == 4)
                chk(log_nack[base+i] == e_nack[i], {req, " nack"}, log_nack[base+i], e_nack[i]);
        end
        base = log_n; e_n = 0;
    endtask

    task automatic push(bit sto, bit sta, int b);
        @(negedge clk);
        cmd_wr = 1'b1; cmd_word = {sto, sta, 8'(b)};
        @(negedge clk);
        cmd_wr = 1'b0;
    endtask

    task automatic wait_idle();
        int quiet = 0;
        for (int t = 0; t < 2000 && quiet < 4; t++) begin
            @(negedge clk);
            if (tx_empty && !eng_req) quiet++; else quiet = 0;
        end
    endtask

    task automatic pop_chk(string req);
        @(negedge clk);
        chk(!rx_empty, {req, " rx not empty"}, int'(rx_empty), 0);
        chk(rx_byte == 8'(pop_seq), {req, " rx order"}, int'(rx_byte), pop_seq & 255);
        pop_seq++;
        rx_pop = 1'b1;
        @(negedge clk);
        rx_pop = 1'b0;
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_bad++;
        $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk + 1, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R11: reset state
        chk(tx_empty && rx_empty && tx_level == 0, "R11 queues empty", int'(tx_level), 0);
        chk(!eng_req && !bus_busy && !tx_overflow && !proto_err && !tx_full && !rx_full,
            "R11 flags clear", int'({eng_req, bus_busy, tx_overflow, proto_err}), 0);
        rst_n = 1'b1;

        // R3: address-only write with start and stop in one word
        push(1, 1, 8'hA0);
        wait_idle();
        ex(1, 0, 0); ex(3, 8'hA0, 0); ex(5, 0, 0);
        check_log("R3");
        chk(!bus_busy, "R3 bus released", int'(bus_busy), 0);

        // R1, R5: write transfer with two data bytes, stop on the last
        push(0, 1, 8'h42); push(0, 0, 8'h11); push(1, 0, 8'h22);
        wait_idle();
        ex(1, 0, 0); ex(3, 8'h42, 0); ex(3, 8'h11, 0); ex(3, 8'h22, 0); ex(5, 0, 0);
        check_log("R1 R5");

        // R2, R10: write, then a repeated start into a 3-byte read
        push(0, 1, 8'h20); push(0, 0, 8'h33);
        wait_idle();
        chk(bus_busy, "R10 busy while open", int'(bus_busy), 1);
        push(0, 1, 8'h21); push(1, 0, 3);
        wait_idle();
        chk(!bus_busy, "R10 busy after stop", int'(bus_busy), 0);
        ex(1, 0, 0); ex(3, 8'h20, 0); ex(3, 8'h33, 0); ex(2, 0, 0); ex(3, 8'h21, 0);
        ex(4, 0, 0); ex(4, 0, 0); ex(4, 0, 1); ex(5, 0, 0);
        check_log("R2 R4");
        for (int i = 0; i < 3; i++) pop_chk("R9");
        chk(rx_empty, "R9 rx drained", int'(rx_empty), 1);

        // R4: sweep of read lengths 0..6 with varied engine latency
        for (int n = 0; n <= 6; n++) begin
            lat = n % 3;
            push(0, 1, 8'h0B); push(1, 0, n);
            wait_idle();
            ex(1, 0, 0); ex(3, 8'h0B, 0);
            for (int k = 0; k < n; k++) ex(4, 0, (k == n - 1) ? 1 : 0);
            ex(5, 0, 0);
            check_log("R4 sweep");
            for (int k = 0; k < n; k++) pop_chk("R4 data");
        end
        lat = 2;

        // R8: stray data word with no open transfer
        chk(!proto_err, "R8 error clear before", int'(proto_err), 0);
        push(0, 0, 8'h5A);
        wait_idle();
        check_log("R8 no action");
        chk(proto_err, "R8 error set", int'(proto_err), 1);
        // R8: data word without stop inside an open read is discarded
        push(0, 1, 8'h0D); push(0, 0, 8'h99); push(1, 0, 1);
        wait_idle();
        ex(1, 0, 0); ex(3, 8'h0D, 0); ex(4, 0, 1); ex(5, 0, 0);
        check_log("R8 read discard");
        pop_chk("R8 data");

        // R7: fill the transmit queue while the engine stalls
        hold = 1'b1;
        push(0, 1, 8'h24);
        repeat (4) @(negedge clk);
        for (int i = 1; i <= 15; i++) push(0, 0, i);
        chk(tx_full && tx_level == 16, "R7 full at 16", int'(tx_level), 16);
        chk(!tx_overflow, "R7 no overflow yet", int'(tx_overflow), 0);
        push(1, 0, 8'hEE);
        @(negedge clk);
        chk(tx_overflow, "R7 overflow set", int'(tx_overflow), 1);
        chk(tx_level == 16, "R7 level kept", int'(tx_level), 16);
        hold = 1'b0;
        wait_idle();
        chk(tx_empty && tx_level == 0, "R7 drained", int'(tx_level), 0);
        chk(tx_overflow, "R7 overflow sticky", int'(tx_overflow), 1);
        push(1, 0, 8'h77);
        wait_idle();
        ex(1, 0, 0); ex(3, 8'h24, 0);
        for (int i = 1; i <= 15; i++) ex(3, i, 0);
        ex(3, 8'h77, 0); ex(5, 0, 0);
        check_log("R7 dropped word");

        // R9: 20-byte read with no pops stalls at 16
        push(0, 1, 8'h61); push(1, 0, 20);
        repeat (300) @(negedge clk);
        chk(rx_full, "R9 rx full", int'(rx_full), 1);
        chk(!eng_req, "R9 request withheld", int'(eng_req), 0);
        chk((log_n - base) == 18, "R9 actions before stall", log_n - base, 18);
        for (int i = 0; i < 16; i++) pop_chk("R9 stalled data");
        wait_idle();
        for (int i = 0; i < 4; i++) pop_chk("R9 tail data");
        ex(1, 0, 0); ex(3, 8'h61, 0);
        for (int k = 0; k < 20; k++) ex(4, 0, (k == 19) ? 1 : 0);
        ex(5, 0, 0);
        check_log("R9");
        chk(rx_empty && !bus_busy, "R9 final idle", int'({rx_empty, bus_busy}), 2);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule